// File: doc/BRIEF.md
# Width-Selectable ALU With Status Flags

This block is a purely combinational arithmetic and logic unit for 8-, 16- and 32-bit operands. A two-bit size input selects the working width. An operation code picks one of addition, subtraction, bitwise AND, OR, XOR, a bitwise complement of the first operand, or a plain move of that operand. All arithmetic and all flags are evaluated on the low bits of the two 32-bit operands at the selected width.

The result bits above the selected width are copied from operand A. The output can therefore be written straight back into a wide register, with the same effect as a partial-register update. Six status flags come out beside the result: carry, parity, auxiliary carry, zero, sign and overflow. An instruction pipeline can latch them.

Top module: `width_alu`

## Requirements
- R1: Operation code 0 adds. The low W bits of the result equal (A + B) mod 2^W, where W is the selected width. The carry flag is the unsigned carry out of bit W-1.
- R2: Operation code 1 subtracts. The low W bits equal (A - B) mod 2^W. The carry flag is set exactly when the low W bits of A, read as unsigned, are smaller than those of B (a borrow).
- R3: Operation codes 2, 3, 4 and 5 give A AND B, A OR B, A XOR B and NOT A on the low W bits. For these codes the carry, overflow and auxiliary flags are 0.
- R4: For every operation, the result bits at and above position W equal the same bits of operand A.
- R5: The zero flag is 1 exactly when the low W bits of the result are all 0.
- R6: The sign flag equals result bit W-1.
- R7: The parity flag is 1 when the low 8 bits of the result hold an even number of ones, at every width.
- R8: The overflow flag is set for an add when A and B have the same sign at bit W-1 and the result sign differs. It is set for a subtract when the signs of A and B differ and the result sign differs from that of A.
- R9: The auxiliary flag is the carry out of bit 3 for an add, and the borrow into bit 3 for a subtract (A[3:0] < B[3:0]).
- R10: Size code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 both select 32 bits.
- R11: Operation codes 6 and 7 pass A through unchanged. Carry, overflow and auxiliary are 0, and parity, zero and sign follow the passed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; also the source of the preserved upper bits |
| opB | input | 32 | Second operand |
| opSel | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 not A, 6/7 move A) |
| sizeSel | input | 2 | Width code (0: 8, 1: 16, 2 or 3: 32 bits) |
| result | output | 32 | Merged result |
| carryFlag | output | 1 | Carry out or borrow at the selected width |
| parityFlag | output | 1 | Even parity of result bits 7:0 |
| auxFlag | output | 1 | Carry or borrow across bit 3 |
| zeroFlag | output | 1 | Low W result bits are zero |
| signFlag | output | 1 | Result bit W-1 |
| overflowFlag | output | 1 | Signed overflow at the selected width |

## Verification
The block holds no state, so any fault shows at the outputs in the same cycle as the operands that expose it. A wrong lane select appears as a carry, sign or zero taken from the wrong bit position, or as corrupted upper bits, whenever an operand differs between widths. An inverted borrow sense shows on the first subtraction. Directed vectors aim at each width's carry, borrow and signed boundaries. Random operands at all widths and codes cover the remaining combinations.

// File: rtl/width_alu_pkg.sv
package width_alu_pkg;
  localparam int LANES  = 3;
  localparam int BASE_W = 8;
  localparam int DATA_W = BASE_W << (LANES - 1);
  localparam int OP_W   = 3;
  localparam int SIZE_W = 2;

  // strobes from the decoder to the datapath and flag unit
  typedef struct packed {
    logic             doAdd;
    logic             doSub;
    logic             doAnd;
    logic             doOr;
    logic             doXor;
    logic             doNot;
    logic             doPass;
    logic [LANES-1:0] laneSel;
  } aluCtrl_t;
endpackage

// File: rtl/width_alu_ctrl.sv
module width_alu_ctrl
  import width_alu_pkg::*;
(
  input  logic [OP_W-1:0]   opSel,
  input  logic [SIZE_W-1:0] sizeSel,
  output aluCtrl_t          ctrl
);
  always_comb begin
    ctrl = '0;
    case (opSel)
      3'd0:    ctrl.doAdd = 1'b1;
      3'd1:    ctrl.doSub = 1'b1;
      3'd2:    ctrl.doAnd = 1'b1;
      3'd3:    ctrl.doOr  = 1'b1;
      3'd4:    ctrl.doXor = 1'b1;
      3'd5:    ctrl.doNot = 1'b1;
      default: ctrl.doPass = 1'b1;
    endcase
    // codes beyond the widest lane fold onto the widest lane
    for (int i = 0; i < LANES; i++) begin
      if (i == LANES - 1) ctrl.laneSel[i] = (int'(sizeSel) >= i);
      else                ctrl.laneSel[i] = (int'(sizeSel) == i);
    end
  end
endmodule

// File: rtl/width_alu_datapath.sv
module width_alu_datapath
  import width_alu_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluCtrl_t          ctrl,
  output logic [DATA_W-1:0] result,
  output logic              selCout,
  output logic              selCmsb,
  output logic              nibCarry
);
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] opRes;
  logic [DATA_W-1:0] widthMask;
  logic [LANES-1:0]  laneCout;
  logic [LANES-1:0]  laneCmsb;
  logic [DATA_W-1:0] laneMask [LANES];
  logic              isArith;

  assign isArith = ctrl.doAdd | ctrl.doSub;
  assign bEff    = ctrl.doSub ? ~opB : opB;
  assign sumFull = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, ctrl.doSub};

  // carry entering bit 4 recovered from the sum
  assign nibCarry = sumFull[4] ^ opA[4] ^ bEff[4];

  always_comb begin
    logicRes = opA;
    if (ctrl.doAnd) logicRes = opA & opB;
    if (ctrl.doOr)  logicRes = opA | opB;
    if (ctrl.doXor) logicRes = opA ^ opB;
    if (ctrl.doNot) logicRes = ~opA;
  end

  assign opRes = isArith ? sumFull[DATA_W-1:0] : logicRes;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int W = BASE_W << g;
    assign laneMask[g] = {DATA_W{1'b1}} >> (DATA_W - W);
    if (W == DATA_W) begin : gTop
      assign laneCout[g] = sumFull[DATA_W];
    end else begin : gMid
      assign laneCout[g] = sumFull[W] ^ opA[W] ^ bEff[W];
    end
    assign laneCmsb[g] = sumFull[W-1] ^ opA[W-1] ^ bEff[W-1];
  end

  always_comb begin
    widthMask = '0;
    for (int i = 0; i < LANES; i++)
      if (ctrl.laneSel[i]) widthMask = widthMask | laneMask[i];
  end

  assign selCout = |(laneCout & ctrl.laneSel);
  assign selCmsb = |(laneCmsb & ctrl.laneSel);
  assign result  = (opRes & widthMask) | (opA & ~widthMask);

  // the decoder must hand over exactly one width
  always_comb begin
    AST_ONE_LANE: assert ($onehot(ctrl.laneSel))
      else $error("lane select not one-hot"); // R10
  end
endmodule

// File: rtl/width_alu_flags.sv
module width_alu_flags
  import width_alu_pkg::*;
(
  input  logic [DATA_W-1:0] result,
  input  logic [LANES-1:0]  laneSel,
  input  logic              isArith,
  input  logic              isSub,
  input  logic              selCout,
  input  logic              selCmsb,
  input  logic              nibCarry,
  output logic              carryFlag,
  output logic              parityFlag,
  output logic              auxFlag,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              overflowFlag
);
  logic [LANES-1:0] laneZero;
  logic [LANES-1:0] laneSign;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int W = BASE_W << g;
    assign laneZero[g] = (result[W-1:0] == '0);
    assign laneSign[g] = result[W-1];
  end

  assign zeroFlag     = |(laneZero & laneSel);
  assign signFlag     = |(laneSign & laneSel);
  assign parityFlag   = ~^result[BASE_W-1:0];
  assign carryFlag    = isArith & (selCout ^ isSub);
  assign auxFlag      = isArith & (nibCarry ^ isSub);
  assign overflowFlag = isArith & (selCout ^ selCmsb);

  always_comb begin
    // an all-zero low byte always has even parity
    AST_ZERO_PARITY: assert (!zeroFlag || parityFlag)
      else $error("zero result without even parity"); // R7
    AST_ZERO_NOT_NEG: assert (!(zeroFlag && signFlag))
      else $error("zero result flagged negative"); // R6
  end
endmodule

// File: rtl/width_alu.sv
module width_alu
  import width_alu_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [2:0]  opSel,
  input  logic [1:0]  sizeSel,
  output logic [31:0] result,
  output logic        carryFlag,
  output logic        parityFlag,
  output logic        auxFlag,
  output logic        zeroFlag,
  output logic        signFlag,
  output logic        overflowFlag
);
  aluCtrl_t ctrl;
  logic     selCout;
  logic     selCmsb;
  logic     nibCarry;

  width_alu_ctrl uCtrl (
    .opSel   (opSel),
    .sizeSel (sizeSel),
    .ctrl    (ctrl)
  );

  width_alu_datapath uPath (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .selCout  (selCout),
    .selCmsb  (selCmsb),
    .nibCarry (nibCarry)
  );

  width_alu_flags uFlags (
    .result       (result),
    .laneSel      (ctrl.laneSel),
    .isArith      (ctrl.doAdd | ctrl.doSub),
    .isSub        (ctrl.doSub),
    .selCout      (selCout),
    .selCmsb      (selCmsb),
    .nibCarry     (nibCarry),
    .carryFlag    (carryFlag),
    .parityFlag   (parityFlag),
    .auxFlag      (auxFlag),
    .zeroFlag     (zeroFlag),
    .signFlag     (signFlag),
    .overflowFlag (overflowFlag)
  );

  always_comb begin
    if (opSel >= 3'd2) begin
      AST_LOGIC_CLEAR: assert (!carryFlag && !overflowFlag && !auxFlag)
        else $error("non-arithmetic code raised an arithmetic flag"); // R3
    end
    if (sizeSel == 2'd0) begin
      AST_UPPER_KEEP8: assert (result[31:8] == opA[31:8])
        else $error("upper bits not preserved at 8-bit width"); // R4
    end
    if (sizeSel == 2'd1) begin
      AST_UPPER_KEEP16: assert (result[31:16] == opA[31:16])
        else $error("upper bits not preserved at 16-bit width"); // R4
    end
  end
endmodule

// File: tb/width_alu_test.sv
module width_alu_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [31:0] expRes;
    logic [5:0]  expFlags; // {carry, parity, aux, zero, sign, overflow}
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opSel = '0;
  logic [1:0]  sizeSel = '0;
  logic [31:0] result;
  logic        carryFlag, parityFlag, auxFlag, zeroFlag, signFlag, overflowFlag;

  item_t scoreQ[$];
  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  width_alu uut (
    .opA          (opA),
    .opB          (opB),
    .opSel        (opSel),
    .sizeSel      (sizeSel),
    .result       (result),
    .carryFlag    (carryFlag),
    .parityFlag   (parityFlag),
    .auxFlag      (auxFlag),
    .zeroFlag     (zeroFlag),
    .signFlag     (signFlag),
    .overflowFlag (overflowFlag)
  );

  // independent model written from the requirements
  function automatic item_t predict(logic [31:0] a, logic [31:0] b, logic [2:0] op,
                                    logic [1:0] sz, string tag);
    item_t it;
    int w;
    logic [31:0] m, r, full;
    logic [32:0] am, bm, s;
    logic c, ax, ov, sa, sb, sr;
    w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    am = {1'b0, a & m};
    bm = {1'b0, b & m};
    c = 1'b0; ax = 1'b0; ov = 1'b0;
    sa = a[w-1]; sb = b[w-1];
    case (op)
      3'd0: begin
        s = am + bm; r = s[31:0] & m; c = s[w];
        ax = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
        sr = r[w-1]; ov = (sa == sb) && (sr != sa);
      end
      3'd1: begin
        s = am - bm; r = s[31:0] & m; c = am < bm;
        ax = a[3:0] < b[3:0];
        sr = r[w-1]; ov = (sa != sb) && (sr != sa);
      end
      3'd2: r = a & b & m;
      3'd3: r = (a | b) & m;
      3'd4: r = (a ^ b) & m;
      3'd5: r = ~a & m;
      default: r = a & m;
    endcase
    full = r | (a & ~m);
    it.a = a; it.b = b; it.op = op; it.sz = sz; it.tag = tag;
    it.expRes   = full;
    it.expFlags = {c, ~^full[7:0], ax, (r == 32'h0), full[w-1], ov};
    return it;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] op,
                       logic [1:0] sz, string tag);
    @(posedge clk);
    #1;
    opA = a; opB = b; opSel = op; sizeSel = sz;
    scoreQ.push_back(predict(a, b, op, sz, tag));
  endtask

  // monitor: compare half a cycle after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (scoreQ.size() > 0) begin
        item_t it;
        logic [5:0] got;
        it  = scoreQ.pop_front();
        got = {carryFlag, parityFlag, auxFlag, zeroFlag, signFlag, overflowFlag};
        checks++;
        if (result !== it.expRes || got !== it.expFlags) begin
          fails++;
          $display("FAIL %s op=%0d size=%0d a=%h b=%h: result=%h flags=%b expected result=%h flags=%b",
                   it.tag, it.op, it.sz, it.a, it.b, result, got, it.expRes, it.expFlags);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // initial state: all-zero operands
    drive(32'h0, 32'h0, 3'd0, 2'd0, "R5 idle zero");
    // R1 carries at each width
    drive(32'h0000_00FF, 32'h1, 3'd0, 2'd0, "R1 add8 carry");
    drive(32'h0000_FFFF, 32'h1, 3'd0, 2'd1, "R1 add16 carry");
    drive(32'hFFFF_FFFF, 32'h1, 3'd0, 2'd2, "R1 add32 carry");
    drive(32'h1234_5678, 32'h0000_0010, 3'd0, 2'd0, "R4 add8 upper kept");
    drive(32'hABCD_FFF0, 32'h0000_0020, 3'd0, 2'd1, "R4 add16 upper kept");
    // R2 borrows
    drive(32'h0, 32'h1, 3'd1, 2'd0, "R2 sub8 borrow");
    drive(32'h5, 32'h7, 3'd1, 2'd2, "R2 sub32 borrow");
    drive(32'h9, 32'h3, 3'd1, 2'd1, "R2 sub16 no borrow");
    // R8 signed overflow
    drive(32'h7F, 32'h1, 3'd0, 2'd0, "R8 add8 overflow");
    drive(32'h80, 32'h1, 3'd1, 2'd0, "R8 sub8 overflow");
    drive(32'h8000, 32'h1, 3'd1, 2'd1, "R8 sub16 overflow");
    drive(32'h7FFF_FFFF, 32'h1, 3'd0, 2'd2, "R8 add32 overflow");
    drive(32'hFF, 32'hFF, 3'd0, 2'd0, "R8 add8 neg no overflow");
    // R9 nibble carry
    drive(32'h0F, 32'h01, 3'd0, 2'd0, "R9 add aux");
    drive(32'h10, 32'h01, 3'd1, 2'd0, "R9 sub aux");
    // R3 logic codes
    drive(32'hF0F0_F0F0, 32'hFF00_FF00, 3'd2, 2'd2, "R3 and32");
    drive(32'hF0F0_F0F0, 32'h0F0F_000F, 3'd3, 2'd1, "R3 or16");
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd4, 2'd0, "R3 xor8");
    drive(32'h1234_56FF, 32'h0, 3'd5, 2'd0, "R3 not8");
    // R6 sign at 16 bits while lower byte is positive
    drive(32'h0000_8001, 32'h0, 3'd0, 2'd1, "R6 sign16");
    // R7 parity over the low byte only
    drive(32'h0100_0003, 32'h0, 3'd0, 2'd2, "R7 parity even");
    drive(32'h0000_0007, 32'h0, 3'd0, 2'd2, "R7 parity odd");
    // R10 size code 3 behaves as 32 bits
    drive(32'hFFFF_FFFF, 32'h1, 3'd0, 2'd3, "R10 size3 add");
    drive(32'h8000_0000, 32'h1, 3'd1, 2'd3, "R10 size3 sub");
    // R11 move codes
    drive(32'hDEAD_BE00, 32'h1234_5678, 3'd6, 2'd0, "R11 move6");
    drive(32'h8000_0000, 32'hFFFF_FFFF, 3'd7, 2'd2, "R11 move7");
    // random coverage over every code and size
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      drive($urandom, $urandom, op, 2'($urandom_range(0, 3)),
            (op == 3'd0) ? "R1 random add" : (op == 3'd1) ? "R2 random sub" :
            (op <= 3'd5) ? "R3 random logic" : "R11 random move");
    end
    while (scoreQ.size() > 0) @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule